// File: doc/BRIEF.md
# DSP Auxiliary Address Generator

This block generates operand addresses for a 16-bit fixed-point signal processor. It holds a bank of pointer registers and one buffer-length register. Two access ports each name a pointer, an addressing mode and a signed displacement. Each port returns an operand address in the same cycle. At the next clock edge, each port may write an updated pointer back to the register it named. Two operands can therefore be addressed in one cycle, for example a coefficient and a sample in a multiply-accumulate loop.

Pointer register 0 has a second role: it is the stride for the indexed, bit-reversed and circular-indexed modes. Circular modes keep a pointer inside a buffer whose length is the buffer-length register. The buffer starts on a power-of-two boundary, so a pointer wraps without any software re-initialisation. The bit-reversed mode lets FFT data be walked in reversed-index order. A load path writes any pointer or the buffer length directly.

Top module: `dsp_addr_gen`

## Requirements
- R1: While reset is active and after it is released, every pointer register and the buffer-length register read as zero.
- R2: A load writes its value into the chosen pointer at the next edge. A load takes priority over any port update of the same register in that cycle.
- R3: Mode 0 (plain) returns the pointer as the address and leaves it unchanged. A port with its enable low never changes a register, whatever its mode.
- R4: Mode 1 (displaced) returns pointer plus the signed displacement, modulo 2^AW. When the write-back flag is set, that sum becomes the new pointer. When the flag is clear, the pointer is unchanged.
- R5: Mode 2 returns the pointer and then adds 1 to it. Mode 3 returns the pointer and then subtracts 1. Both wrap modulo 2^AW.
- R6: Mode 4 returns the pointer and then adds register 0 to it. The value of register 0 used is the one held at the start of the cycle.
- R7: Mode 5 returns the pointer and then adds register 0 with the carry rippling from bit AW-1 toward bit 0. Any carry out of bit 0 is dropped.
- R8: Mode 6 returns the pointer and then adds the signed displacement inside a circular buffer. The buffer length L is the buffer-length register, and the step magnitude must not exceed L. The buffer base is the pointer with its low bits cleared, below the smallest power of two that is at least L. The new pointer is the base plus ((offset from base + step) mod L).
- R9: Mode 7 works like mode 6, but the step is register 0 taken as unsigned.
- R10: With a buffer length of zero, modes 6 and 7 update as a plain linear add modulo 2^AW.
- R11: Both ports work in the same cycle on independent registers. If both update the same register, the port A result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load a pointer register |
| ld_sel | input | SW | Pointer register to load |
| ld_val | input | AW | Value to load |
| bk_en | input | 1 | Load the buffer-length register |
| bk_val | input | AW | Buffer length |
| a_en | input | 1 | Port A allowed to update its pointer |
| a_sel | input | SW | Port A pointer register |
| a_mode | input | 3 | Port A addressing mode (0..7) |
| a_ofs | input | AW | Port A signed displacement / circular step |
| a_wb | input | 1 | Port A write-back for mode 1 |
| a_addr | output | AW | Port A operand address |
| b_en | input | 1 | Port B allowed to update its pointer |
| b_sel | input | SW | Port B pointer register |
| b_mode | input | 3 | Port B addressing mode (0..7) |
| b_ofs | input | AW | Port B signed displacement / circular step |
| b_wb | input | 1 | Port B write-back for mode 1 |
| b_addr | output | AW | Port B operand address |

## Verification
The bench builds the block with AW=8 and the default eight registers. With an 8-bit address space, the bit-reversed add can be swept over every pointer value for several strides. The circular modes can be swept over every buffer length from 0 to 20, every start offset inside the buffer, and every step from -L to +L. Expected pointers are derived arithmetically: a modulo reduction for the circular modes and an explicit top-down carry for the reversed add. Directed cycles then cover same-cycle port collisions, load priority, and port B reading the old register 0.

// File: rtl/dag_pkg.sv
`timescale 1ns/1ps
package dag_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN = 3'd0,
    AM_DISP  = 3'd1,
    AM_INC   = 3'd2,
    AM_DEC   = 3'd3,
    AM_IDX   = 3'd4,
    AM_REV   = 3'd5,
    AM_CSTEP = 3'd6,
    AM_CIDX  = 3'd7
  } am_mode_e;

  function automatic logic is_circ(am_mode_e m);
    return (m == AM_CSTEP) || (m == AM_CIDX);
  endfunction
endpackage

// File: rtl/dag_rst_sync.sv
`timescale 1ns/1ps
module dag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/dag_modulo.sv
`timescale 1ns/1ps
module dag_modulo #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW:0]   step,
  input  logic [AW-1:0] blen,
  output logic [AW-1:0] nxt
);
  localparam int SUMW = AW + 2;

  logic [AW-1:0]          bm1;
  logic [AW-1:0]          smear;
  logic [AW-1:0]          base;
  logic [AW-1:0]          idx;
  logic signed [SUMW-1:0] sum;
  logic signed [SUMW-1:0] len_s;
  logic signed [SUMW-1:0] adj;

  assign bm1 = blen - AW'(1);

  // mask covering the smallest power of two at or above blen
  always_comb begin
    smear[AW-1] = bm1[AW-1];
    for (int k = AW - 2; k >= 0; k--) smear[k] = smear[k+1] | bm1[k];
  end

  assign base  = ptr & ~smear;
  assign idx   = ptr & smear;
  assign len_s = $signed({2'b00, blen});
  assign sum   = $signed({2'b00, idx}) + $signed({step[AW], step});

  always_comb begin
    if (sum < 0)          adj = sum + len_s;
    else if (sum >= len_s) adj = sum - len_s;
    else                  adj = sum;
  end

  always_comb begin
    if (blen == '0) nxt = ptr + step[AW-1:0];
    else            nxt = base + adj[AW-1:0];
  end
endmodule

// File: rtl/dag_port_calc.sv
`timescale 1ns/1ps
module dag_port_calc
  import dag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          en,
  input  am_mode_e      mode,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] ar0,
  input  logic [AW-1:0] ofs,
  input  logic          wb,
  input  logic [AW-1:0] blen,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nxt,
  output logic          we
);
  logic [AW:0]   cstep;
  logic [AW-1:0] circ_nxt;
  logic [AW-1:0] rev_sum;
  logic [AW-1:0] disp_sum;
  logic          wr_req;

  assign cstep    = (mode == AM_CIDX) ? {1'b0, ar0} : {ofs[AW-1], ofs};
  assign disp_sum = ptr + ofs;

  dag_modulo #(.AW(AW)) i_mod (
    .ptr  (ptr),
    .step (cstep),
    .blen (blen),
    .nxt  (circ_nxt)
  );

  // reverse-carry add: carry runs from the top bit downward
  always_comb begin
    logic c;
    c = 1'b0;
    for (int k = AW - 1; k >= 0; k--) begin
      rev_sum[k] = ptr[k] ^ ar0[k] ^ c;
      c          = (ptr[k] & ar0[k]) | (c & (ptr[k] ^ ar0[k]));
    end
  end

  always_comb begin
    addr   = ptr;
    nxt    = ptr;
    wr_req = 1'b1;
    unique case (mode)
      AM_PLAIN: wr_req = 1'b0;
      AM_DISP: begin
        addr   = disp_sum;
        nxt    = disp_sum;
        wr_req = wb;
      end
      AM_INC:   nxt = ptr + AW'(1);
      AM_DEC:   nxt = ptr - AW'(1);
      AM_IDX:   nxt = ptr + ar0;
      AM_REV:   nxt = rev_sum;
      AM_CSTEP, AM_CIDX: nxt = circ_nxt;
      default:  wr_req = 1'b0;
    endcase
  end

  assign we = en & wr_req;
endmodule

// File: rtl/dag_regfile.sv
`timescale 1ns/1ps
module dag_regfile #(
  parameter int NREG = 8,
  parameter int AW   = 16,
  localparam int SW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [SW-1:0]            ld_sel,
  input  logic [AW-1:0]            ld_val,
  input  logic                     bk_en,
  input  logic [AW-1:0]            bk_val,
  input  logic                     wa_en,
  input  logic [SW-1:0]            wa_sel,
  input  logic [AW-1:0]            wa_val,
  input  logic                     wb_en,
  input  logic [SW-1:0]            wb_sel,
  input  logic [AW-1:0]            wb_val,
  output logic [NREG-1:0][AW-1:0]  ptr_o,
  output logic [AW-1:0]            blen_o
);
  logic [NREG-1:0][AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0]           blen_q, blen_d;

  // priority, lowest first: port B, port A, load
  always_comb begin
    ptr_d = ptr_q;
    if (wb_en) ptr_d[wb_sel] = wb_val;
    if (wa_en) ptr_d[wa_sel] = wa_val;
    if (ld_en) ptr_d[ld_sel] = ld_val;
    blen_d = bk_en ? bk_val : blen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      blen_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      blen_q <= blen_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign blen_o = blen_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ptr_q[$past(ld_sel)] == $past(ld_val));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !wa_en && !wb_en) |=> $stable(ptr_q));

  p_blen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bk_en |=> $stable(blen_q));
endmodule

// File: rtl/dsp_addr_gen.sv
`timescale 1ns/1ps
module dsp_addr_gen
  import dag_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 16,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [AW-1:0] ld_val,
  input  logic          bk_en,
  input  logic [AW-1:0] bk_val,
  input  logic          a_en,
  input  logic [SW-1:0] a_sel,
  input  logic [2:0]    a_mode,
  input  logic [AW-1:0] a_ofs,
  input  logic          a_wb,
  output logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic [SW-1:0] b_sel,
  input  logic [2:0]    b_mode,
  input  logic [AW-1:0] b_ofs,
  input  logic          b_wb,
  output logic [AW-1:0] b_addr
);
  localparam int NPORT = 2;

  logic                    rst_q;
  logic [NREG-1:0][AW-1:0] ptr;
  logic [AW-1:0]           blen;
  logic [NPORT-1:0]        p_en, p_we, p_wb;
  logic [NPORT-1:0][SW-1:0] p_sel;
  logic [NPORT-1:0][2:0]   p_mode;
  logic [NPORT-1:0][AW-1:0] p_ofs, p_addr, p_nxt;

  dag_rst_sync #(.STAGES(2)) i_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign p_en   = {b_en, a_en};
  assign p_sel  = {b_sel, a_sel};
  assign p_mode = {b_mode, a_mode};
  assign p_ofs  = {b_ofs, a_ofs};
  assign p_wb   = {b_wb, a_wb};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dag_port_calc #(.AW(AW)) i_calc (
      .en   (p_en[g]),
      .mode (am_mode_e'(p_mode[g])),
      .ptr  (ptr[p_sel[g]]),
      .ar0  (ptr[0]),
      .ofs  (p_ofs[g]),
      .wb   (p_wb[g]),
      .blen (blen),
      .addr (p_addr[g]),
      .nxt  (p_nxt[g]),
      .we   (p_we[g])
    );
  end

  dag_regfile #(.NREG(NREG), .AW(AW)) i_rf (
    .clk    (clk),
    .rst_n  (rst_q),
    .ld_en  (ld_en),
    .ld_sel (ld_sel),
    .ld_val (ld_val),
    .bk_en  (bk_en),
    .bk_val (bk_val),
    .wa_en  (p_we[0]),
    .wa_sel (a_sel),
    .wa_val (p_nxt[0]),
    .wb_en  (p_we[1]),
    .wb_sel (b_sel),
    .wb_val (p_nxt[1]),
    .ptr_o  (ptr),
    .blen_o (blen)
  );

  assign a_addr = p_addr[0];
  assign b_addr = p_addr[1];

  p_post_inc_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (a_en && a_mode == 3'(AM_INC) && !(ld_en && ld_sel == a_sel))
      |=> ptr[$past(a_sel)] == $past(a_addr) + AW'(1));

  p_collide_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (p_we[0] && p_we[1] && a_sel == b_sel && !(ld_en && ld_sel == a_sel))
      |=> ptr[$past(a_sel)] == $past(p_nxt[0]));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (!a_en && !b_en && !ld_en) |=> $stable(ptr));

  p_linear_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (a_en && a_mode == 3'(AM_CSTEP) && blen == '0 && !(ld_en && ld_sel == a_sel))
      |=> ptr[$past(a_sel)] == $past(a_addr) + $past(a_ofs));

  p_disp_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (a_mode == 3'(AM_DISP)) |-> a_addr == ptr[a_sel] + a_ofs);
endmodule

// File: tb/test_dsp_addr_gen.sv
`timescale 1ns/1ps
module test_dsp_addr_gen;
  localparam int NREG = 8;
  localparam int AW   = 8;
  localparam int SW   = 3;
  localparam int MSK  = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0, bk_en = 1'b0;
  logic [SW-1:0] ld_sel = '0;
  logic [AW-1:0] ld_val = '0, bk_val = '0;
  logic          a_en = 1'b0, b_en = 1'b0, a_wb = 1'b0, b_wb = 1'b0;
  logic [SW-1:0] a_sel = '0, b_sel = '0;
  logic [2:0]    a_mode = '0, b_mode = '0;
  logic [AW-1:0] a_ofs = '0, b_ofs = '0;
  logic [AW-1:0] a_addr, b_addr;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dsp_addr_gen #(.NREG(NREG), .AW(AW)) i_dsp_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
    .bk_en(bk_en), .bk_val(bk_val),
    .a_en(a_en), .a_sel(a_sel), .a_mode(a_mode), .a_ofs(a_ofs), .a_wb(a_wb), .a_addr(a_addr),
    .b_en(b_en), .b_sel(b_sel), .b_mode(b_mode), .b_ofs(b_ofs), .b_wb(b_wb), .b_addr(b_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_rev(int p, int s);
    int r = 0;
    int c = 0;
    for (int k = AW - 1; k >= 0; k--) begin
      int t = ((p >> k) & 1) + ((s >> k) & 1) + c;
      r = r | ((t & 1) << k);
      c = t >> 1;
    end
    return r;
  endfunction

  function automatic int f_circ(int p, int step, int len);
    int sz = 1;
    int base, i;
    if (len == 0) return (p + step) & MSK;
    while (sz < len) sz = sz * 2;
    base = p - (p % sz);
    i    = p % sz;
    return base + (((i + step) % len) + len) % len;
  endfunction

  task automatic idle();
    a_en = 1'b0; b_en = 1'b0; ld_en = 1'b0; bk_en = 1'b0;
    a_mode = 3'd0; b_mode = 3'd0; a_wb = 1'b0; b_wb = 1'b0;
  endtask

  task automatic load(input int r, input int v);
    @(negedge clk);
    idle();
    ld_en = 1'b1; ld_sel = SW'(r); ld_val = AW'(v);
    @(posedge clk);
    #1 ld_en = 1'b0;
  endtask

  task automatic set_len(input int v);
    @(negedge clk);
    idle();
    bk_en = 1'b1; bk_val = AW'(v);
    @(posedge clk);
    #1 bk_en = 1'b0;
  endtask

  // read a pointer through port B in plain mode with enable low
  task automatic peek(input int r, output int v);
    @(negedge clk);
    idle();
    b_sel = SW'(r);
    #1 v = int'(b_addr);
  endtask

  task automatic op_a(input int r, input int mode, input int ofs, input bit wb,
                      input int exp_addr, input int exp_new, input string req);
    int v;
    @(negedge clk);
    idle();
    a_en = 1'b1; a_sel = SW'(r); a_mode = 3'(mode); a_ofs = AW'(ofs); a_wb = wb;
    #1 chk(int'(a_addr) == (exp_addr & MSK), req, int'(a_addr), exp_addr & MSK);
    @(posedge clk);
    #1 idle();
    peek(r, v);
    chk(v == (exp_new & MSK), req, v, exp_new & MSK);
  endtask

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    // R1: reset state visible while reset active
    for (int r = 0; r < NREG; r++) begin
      b_sel = SW'(r);
      #1 chk(b_addr == '0, "R1", int'(b_addr), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int r = 0; r < NREG; r++) begin
      peek(r, v);
      chk(v == 0, "R1", v, 0);
    end

    // R2: loads into every register
    for (int r = 0; r < NREG; r++) load(r, 17 * r + 3);
    for (int r = 0; r < NREG; r++) begin
      peek(r, v);
      chk(v == 17 * r + 3, "R2", v, 17 * r + 3);
    end

    // R3: plain mode, and disabled port in an updating mode
    op_a(5, 0, 0, 1'b0, 88, 88, "R3");
    @(negedge clk);
    idle();
    a_sel = 3'd5; a_mode = 3'd2;
    @(posedge clk);
    #1 idle();
    peek(5, v);
    chk(v == 88, "R3", v, 88);

    // R4: displaced with and without write-back
    for (int o = -4; o <= 4; o++) begin
      load(2, 250);
      op_a(2, 1, o, 1'b0, 250 + o, 250, "R4");
      op_a(2, 1, o, 1'b1, 250 + o, 250 + o, "R4");
    end

    // R5: increment and decrement with wrap
    load(3, 255);
    op_a(3, 2, 0, 1'b0, 255, 0, "R5");
    op_a(3, 3, 0, 1'b0, 0, 255, "R5");
    for (int p = 0; p < 256; p += 37) begin
      load(4, p);
      op_a(4, 2, 0, 1'b0, p, p + 1, "R5");
      op_a(4, 3, 0, 1'b0, p + 1, p, "R5");
    end

    // R6: indexed by register 0
    load(0, 9);
    load(6, 250);
    op_a(6, 4, 0, 1'b0, 250, 259, "R6");

    // R7: reverse-carry add over all pointers for several strides
    for (int s = 1; s < 256; s = s * 4) begin
      load(0, s);
      for (int p = 0; p < 256; p++) begin
        load(6, p);
        op_a(6, 5, 0, 1'b0, p, f_rev(p, s), "R7");
      end
    end
    // R7: eight-point reversed order from 0 with stride 4
    load(0, 4);
    load(1, 0);
    begin
      int seq[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
      for (int k = 0; k < 8; k++) op_a(1, 5, 0, 1'b0, seq[k], seq[(k + 1) % 8], "R7");
    end

    // R8 / R10: circular with signed displacement step
    for (int len = 0; len <= 20; len++) begin
      set_len(len);
      for (int i = 0; i < ((len == 0) ? 1 : len); i++) begin
        for (int st = -len; st <= len; st++) begin
          int p = 96 + i;
          load(3, p);
          op_a(3, 6, st, 1'b0, p, f_circ(p, st, len), (len == 0) ? "R10" : "R8");
        end
      end
    end

    // R9 / R10: circular with register 0 step
    for (int len = 0; len <= 12; len++) begin
      set_len(len);
      for (int st = 0; st <= len; st++) begin
        load(0, st);
        for (int i = 0; i < ((len == 0) ? 1 : len); i++) begin
          int p = 160 + i;
          load(5, p);
          op_a(5, 7, 0, 1'b0, p, f_circ(p, st, len), (len == 0) ? "R10" : "R9");
        end
      end
    end
    set_len(0);

    // R11: both ports on different registers
    load(4, 10);
    load(5, 20);
    @(negedge clk);
    idle();
    a_en = 1'b1; a_sel = 3'd4; a_mode = 3'd2;
    b_en = 1'b1; b_sel = 3'd5; b_mode = 3'd3;
    #1 chk(a_addr == 8'd10 && b_addr == 8'd20, "R11", int'(b_addr), 20);
    @(posedge clk);
    #1 idle();
    peek(4, v); chk(v == 11, "R11", v, 11);
    peek(5, v); chk(v == 19, "R11", v, 19);

    // R11: collision on one register, port A wins
    @(negedge clk);
    idle();
    a_en = 1'b1; a_sel = 3'd4; a_mode = 3'd2;
    b_en = 1'b1; b_sel = 3'd4; b_mode = 3'd3;
    @(posedge clk);
    #1 idle();
    peek(4, v); chk(v == 12, "R11", v, 12);

    // R2: load beats port update on same register
    @(negedge clk);
    idle();
    a_en = 1'b1; a_sel = 3'd4; a_mode = 3'd2;
    ld_en = 1'b1; ld_sel = 3'd4; ld_val = 8'd50;
    @(posedge clk);
    #1 idle();
    peek(4, v); chk(v == 50, "R2", v, 50);

    // R6: port B sees register 0 from start of cycle while A bumps it
    load(0, 3);
    load(2, 10);
    @(negedge clk);
    idle();
    a_en = 1'b1; a_sel = 3'd0; a_mode = 3'd2;
    b_en = 1'b1; b_sel = 3'd2; b_mode = 3'd4;
    @(posedge clk);
    #1 idle();
    peek(2, v); chk(v == 13, "R6", v, 13);
    peek(0, v); chk(v == 4, "R6", v, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule